// File: doc/BRIEF.md
# Infrared Frame Transmitter with Zero-Bit Insertion

This block turns a byte stream into a framed serial bit stream for a medium-rate infrared link. A start request begins a frame. The block sends a programmable number of opening flags, and never fewer than two. It then sends the payload bytes least significant bit first and appends a 16-bit frame check sequence. A single closing flag ends the frame. Inside the payload and the check sequence, a 0 is inserted after every run of five 1s, so the flag pattern cannot appear in the frame body.

The block sends one bit for each pulse on `bitStrobe`, which comes from the line timing logic. The rate that timing logic should use is captured at frame start and held on `lineRate` until the frame ends. Bytes arrive over a valid/ready/last handshake into a one-byte holding slot. If that slot is empty when the next byte is due, the frame is cut short with a run of 1s. While a frame is in progress, `txBusy` is high and `rxEnable` is low, which keeps the local receiver off.

Top module: `irFrameTx`

## Requirements
- R1: A frame is sent as opening flags, then the payload bytes least significant bit first, then the check sequence, then one closing flag. The flag is 8'h7E, sent bit 0 first, so the line carries 0,1,1,1,1,1,1,0. Frame bits change only on a `bitStrobe` cycle.
- R2: The number of opening flags is `flagCount`, captured at start. Values of 0 and 1 are raised to 2.
- R3: After five consecutive 1 bits of payload or check sequence, one 0 is inserted. The run count carries across byte boundaries and from the payload into the check sequence. Flag bits are never stuffed and reset the run count. A run of five that ends the check sequence gets its 0 before the closing flag.
- R4: `txBusy` rises in the cycle after an accepted start and stays high until the strobe after the last frame bit. `rxEnable` is low whenever `txBusy` is high.
- R5: A byte is due after the last opening flag and after each payload byte not marked last. If the holding slot is empty when a byte is due, the block sends eight 1 bits, with no check sequence, no closing flag and no stuffing, and then returns to idle.
- R6: `inReady` is high only while opening flags or payload are being sent, the holding slot is empty, and no byte marked last has been taken in this frame.
- R7: `lineRate` takes `rateSel` when a start is accepted (1 = 1.152 Mbit/s, 0 = 0.576 Mbit/s) and holds that value until the frame ends, whatever `rateSel` does meanwhile.
- R8: The check sequence is a bit-reflected CRC with polynomial 0x1021 (right-shift constant 0x8408). It starts at 0xFFFF, runs over the unstuffed payload bits, and is complemented before sending. It is sent bit 0 first, so the low byte goes first.
- R9: After reset, `txBusy` is 0, `rxEnable` is 1, `inReady` is 0 and `lineRate` is 0. When idle, each strobe drives `txBit` to 0.
- R10: `startReq` has no effect while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Starts a frame when idle |
| flagCount | input | FLAG_W | Requested number of opening flags |
| rateSel | input | 1 | Requested line rate, captured at start |
| bitStrobe | input | 1 | One pulse per serial bit time |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte is valid |
| inLast | input | 1 | Marks the final payload byte |
| inReady | output | 1 | Block accepts a payload byte |
| txBit | output | 1 | Serial output bit |
| txBusy | output | 1 | Frame in progress |
| rxEnable | output | 1 | Local receiver allowed, low while sending |
| lineRate | output | 1 | Line rate held for the current frame |

## Verification
The bench targets payloads that force stuffing across byte boundaries: 0xFF 0xFF 0x1F, and a payload byte equal to the flag pattern. A design that resets the run count per byte, or that stuffs flags, moves every later bit and corrupts the check sequence. It starts frames with flag counts of 0 and 5 to catch a missing floor or an off-by-one in the flag loop. It also starves the byte stream after two bytes and after zero bytes. A design that waits for data, or that appends a check sequence after an underrun, breaks the expected run of 1s. A second start pulse during a frame and a change of `rateSel` mid-frame show whether the frame or the held rate is disturbed.

// File: rtl/irTxPkg.sv
package irTxPkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 16;
  localparam logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam int MIN_FLAGS = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_CRC, ST_CLOSE, ST_ABORT, ST_TAIL
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;      // new frame: seed CRC, load flag, clear slot
    logic fetchOk;    // byte intake allowed in this phase
    logic crcShift;   // current unit is the check sequence
    logic emitUnit;   // send next bit of the current unit
    logic emitStuff;  // send an inserted zero
    logic emitConst;  // send constVal
    logic constVal;
    logic countOnes;  // emitted bit takes part in run counting
    logic crcUpd;     // emitted bit feeds the CRC
    logic loadFlag;
    logic loadByte;
  } txCtl_t;
endpackage

// File: rtl/irTxDatapath.sv
module irTxDatapath
  import irTxPkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtl_t            ctl,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              txBit,
  output logic              unitEnd,
  output logic              stuffDue,
  output logic              bufFull,
  output logic              curLast
);
  localparam int POS_W = $clog2(CRC_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [BYTE_W-1:0] shReg, holdData;
  logic [CRC_W-1:0]  crc;
  logic [POS_W-1:0]  bitPos;
  logic [ONES_W-1:0] onesCnt;
  logic              holdLast, lastTaken, nextBit;

  assign inReady  = ctl.fetchOk && !bufFull && !lastTaken;
  assign stuffDue = (onesCnt == ONES_W'(STUFF_RUN));
  assign unitEnd  = (bitPos == (ctl.crcShift ? POS_W'(CRC_W-1) : POS_W'(BYTE_W-1)));
  assign nextBit  = ctl.crcShift ? ~crc[0] : shReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0; holdData <= '0; crc <= CRC_SEED; bitPos <= '0;
      onesCnt <= '0; holdLast <= 1'b0; lastTaken <= 1'b0;
      bufFull <= 1'b0; curLast <= 1'b0; txBit <= 1'b0;
    end else begin
      if (ctl.start) begin
        crc <= CRC_SEED; lastTaken <= 1'b0; bufFull <= 1'b0;
        onesCnt <= '0; bitPos <= '0; shReg <= FLAG_PATTERN; curLast <= 1'b0;
      end
      if (inValid && inReady) begin
        holdData <= inData; holdLast <= inLast;
        bufFull <= 1'b1; lastTaken <= inLast;
      end
      if (ctl.emitStuff) begin
        txBit <= 1'b0;
        onesCnt <= '0;
      end
      if (ctl.emitConst) txBit <= ctl.constVal;
      if (ctl.emitUnit) begin
        txBit  <= nextBit;
        bitPos <= unitEnd ? '0 : bitPos + 1'b1;
        if (ctl.countOnes) onesCnt <= nextBit ? onesCnt + 1'b1 : '0;
        else onesCnt <= '0;
        if (ctl.crcUpd)
          crc <= (crc >> 1) ^ ((crc[0] ^ shReg[0]) ? CRC_POLY_REV : '0);
        else if (ctl.crcShift)
          crc <= crc >> 1;
        if (!ctl.crcShift) shReg <= shReg >> 1;
      end
      if (ctl.loadFlag) shReg <= FLAG_PATTERN;
      if (ctl.loadByte) begin
        shReg <= holdData; curLast <= holdLast; bufFull <= 1'b0;
      end
    end
  end

  // R3: the run counter never passes the insertion threshold
  a_r3_run_limit: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= ONES_W'(STUFF_RUN));
  // R3: an inserted bit is a zero on the line
  a_r3_stuff_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emitStuff |=> !txBit);
  // R5: a held byte survives until it is loaded or a frame restarts
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !ctl.loadByte && !ctl.start) |=> (bufFull && $stable(holdData)));
endmodule

// File: rtl/irTxCtrl.sv
module irTxCtrl
  import irTxPkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [FLAG_W-1:0] flagCount,
  input  logic              rateSel,
  input  logic              bitStrobe,
  input  logic              unitEnd,
  input  logic              stuffDue,
  input  logic              bufFull,
  input  logic              curLast,
  output txCtl_t            ctl,
  output logic              busy,
  output logic              lineRate
);
  localparam int ABORT_CW = $clog2(ABORT_LEN + 1);

  txState_t            state;
  logic [FLAG_W-1:0]   flagsLeft;
  logic [ABORT_CW-1:0] abortCnt;
  logic                rateQ, lastFlag;

  assign busy     = (state != ST_IDLE);
  assign lineRate = rateQ;
  assign lastFlag = (flagsLeft <= FLAG_W'(1));

  always_comb begin
    ctl = '0;
    ctl.fetchOk  = (state == ST_OPEN) || (state == ST_DATA);
    ctl.crcShift = (state == ST_CRC);
    unique case (state)
      ST_IDLE: begin
        if (startReq) ctl.start = 1'b1;
        else if (bitStrobe) ctl.emitConst = 1'b1;
      end
      ST_OPEN: if (bitStrobe) begin
        ctl.emitUnit = 1'b1;
        if (unitEnd && !lastFlag) ctl.loadFlag = 1'b1;
        if (unitEnd && lastFlag && bufFull) ctl.loadByte = 1'b1;
      end
      ST_DATA: if (bitStrobe) begin
        if (stuffDue) ctl.emitStuff = 1'b1;
        else begin
          ctl.emitUnit = 1'b1; ctl.countOnes = 1'b1; ctl.crcUpd = 1'b1;
          if (unitEnd && !curLast && bufFull) ctl.loadByte = 1'b1;
        end
      end
      ST_CRC: if (bitStrobe) begin
        if (stuffDue) ctl.emitStuff = 1'b1;
        else begin
          ctl.emitUnit = 1'b1; ctl.countOnes = 1'b1;
          if (unitEnd) ctl.loadFlag = 1'b1;
        end
      end
      ST_CLOSE: if (bitStrobe) begin
        if (stuffDue) ctl.emitStuff = 1'b1;
        else ctl.emitUnit = 1'b1;
      end
      ST_ABORT: if (bitStrobe) begin
        ctl.emitConst = 1'b1; ctl.constVal = 1'b1;
      end
      default: if (bitStrobe) ctl.emitConst = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; flagsLeft <= '0; abortCnt <= '0; rateQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) begin
          state <= ST_OPEN;
          flagsLeft <= (flagCount < FLAG_W'(MIN_FLAGS)) ? FLAG_W'(MIN_FLAGS) : flagCount;
          rateQ <= rateSel;
        end
        ST_OPEN: if (bitStrobe && unitEnd) begin
          if (!lastFlag) flagsLeft <= flagsLeft - 1'b1;
          else if (bufFull) state <= ST_DATA;
          else begin state <= ST_ABORT; abortCnt <= '0; end
        end
        ST_DATA: if (bitStrobe && !stuffDue && unitEnd) begin
          if (curLast) state <= ST_CRC;
          else if (!bufFull) begin state <= ST_ABORT; abortCnt <= '0; end
        end
        ST_CRC: if (bitStrobe && !stuffDue && unitEnd) state <= ST_CLOSE;
        ST_CLOSE: if (bitStrobe && !stuffDue && unitEnd) state <= ST_TAIL;
        ST_ABORT: if (bitStrobe) begin
          abortCnt <= abortCnt + 1'b1;
          if (abortCnt == ABORT_CW'(ABORT_LEN-1)) state <= ST_TAIL;
        end
        default: if (bitStrobe) state <= ST_IDLE;
      endcase
    end
  end

  // R2: the captured flag count is never below the floor
  a_r2_min_flags: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (flagsLeft >= FLAG_W'(MIN_FLAGS)));
  // R7: the held rate does not move during a frame
  a_r7_rate_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(rateQ)));
  // R10: a start request while busy does not reload the flag counter upward
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && state != ST_OPEN) |=> $stable(flagsLeft));
endmodule

// File: rtl/irFrameTx.sv
module irFrameTx
  import irTxPkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int ABORT_LEN = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [FLAG_W-1:0] flagCount,
  input  logic              rateSel,
  input  logic              bitStrobe,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              txBit,
  output logic              txBusy,
  output logic              rxEnable
  ,output logic             lineRate
);
  txCtl_t ctl;
  logic unitEnd, stuffDue, bufFull, curLast;

  irTxCtrl #(.FLAG_W(FLAG_W), .ABORT_LEN(ABORT_LEN)) ctrlInst (
    .clk(clk), .rstN(rstN), .startReq(startReq), .flagCount(flagCount),
    .rateSel(rateSel), .bitStrobe(bitStrobe), .unitEnd(unitEnd),
    .stuffDue(stuffDue), .bufFull(bufFull), .curLast(curLast),
    .ctl(ctl), .busy(txBusy), .lineRate(lineRate));

  irTxDatapath #(.STUFF_RUN(STUFF_RUN)) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .txBit(txBit), .unitEnd(unitEnd),
    .stuffDue(stuffDue), .bufFull(bufFull), .curLast(curLast));

  assign rxEnable = !txBusy;

  // R6: intake is offered only inside a frame
  a_r6_ready_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txBusy);
  // R1: the line moves only on a strobe
  a_r1_strobe_only: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> $stable(txBit));
endmodule

// File: tb/irFrameTx_test.sv
module irFrameTx_test;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE_DIV = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 1'b0, rateSel = 1'b0, bitStrobe = 1'b0;
  logic [3:0] flagCount = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic inReady, txBit, txBusy, rxEnable, lineRate;

  int compared = 0, mismatched = 0;
  logic expQ[$];
  string tagQ[$];
  logic [7:0] payload[8];
  logic strobeSeen = 1'b0, busySeen = 1'b0;

  irFrameTx uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .flagCount(flagCount),
    .rateSel(rateSel), .bitStrobe(bitStrobe), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady), .txBit(txBit),
    .txBusy(txBusy), .rxEnable(rxEnable), .lineRate(lineRate));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (STROBE_DIV - 1) @(negedge clk);
      bitStrobe = 1'b1;
      @(negedge clk);
      bitStrobe = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // monitor: compare each emitted frame bit against the scoreboard
  always @(posedge clk) begin
    strobeSeen <= bitStrobe;
    busySeen <= txBusy;
  end
  always @(negedge clk) begin
    if (strobeSeen && busySeen && expQ.size() > 0) begin
      logic e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(txBit === e, t, txBit, e);
    end
  end

  task automatic pushBit(input logic b, input string t);
    expQ.push_back(b);
    tagQ.push_back(t);
  endtask

  task automatic pushFlag(input string t);
    for (int i = 0; i < 8; i++) pushBit(((8'h7E >> i) & 1) != 0, t);
  endtask

  // driver: build expected bits from the requirements, then run the frame
  task automatic runFrame(input int flagsIn, input int nSend, input bit complete, input bit rate);
    int nFlags, ones;
    logic [15:0] crc, fcs;
    nFlags = (flagsIn < 2) ? 2 : flagsIn;        // R2
    for (int f = 0; f < nFlags; f++) pushFlag("R2");
    ones = 0;
    crc = 16'hFFFF;
    for (int i = 0; i < nSend; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic b;
        if (ones == 5) begin pushBit(1'b0, "R3"); ones = 0; end
        b = payload[i][k];
        pushBit(b, "R1");
        ones = b ? ones + 1 : 0;
        crc = (crc >> 1) ^ (((crc[0] ^ b) != 0) ? 16'h8408 : 16'h0000);   // R8
      end
    end
    if (complete) begin
      fcs = ~crc;
      for (int k = 0; k < 16; k++) begin
        if (ones == 5) begin pushBit(1'b0, "R3"); ones = 0; end
        pushBit(fcs[k], "R8");
        ones = fcs[k] ? ones + 1 : 0;
      end
      if (ones == 5) pushBit(1'b0, "R3");
      pushFlag("R1");
    end else begin
      for (int k = 0; k < 8; k++) pushBit(1'b1, "R5");
    end

    @(negedge clk);
    startReq = 1'b1; flagCount = 4'(flagsIn); rateSel = rate;
    @(negedge clk);
    startReq = 1'b0; rateSel = ~rate;
    check(txBusy === 1'b1, "R4", txBusy, 1);
    check(rxEnable === 1'b0, "R4", rxEnable, 0);
    check(lineRate === rate, "R7", lineRate, rate);
    @(negedge clk); startReq = 1'b1;   // R10: stray start during frame
    @(negedge clk); startReq = 1'b0;
    for (int i = 0; i < nSend; i++) begin
      @(negedge clk);
      inData = payload[i]; inValid = 1'b1;
      inLast = complete && (i == nSend - 1);
      do @(posedge clk); while (!inReady);
      @(negedge clk);
      inValid = 1'b0;
      if (inLast) check(inReady === 1'b0, "R6", inReady, 0);
      inLast = 1'b0;
    end
    wait (expQ.size() == 0);
    check(lineRate === rate, "R7", lineRate, rate);
    repeat (3 * STROBE_DIV) @(negedge clk);
    check(txBusy === 1'b0, "R4", txBusy, 0);
    check(rxEnable === 1'b1, "R4", rxEnable, 1);
    check(inReady === 1'b0, "R6", inReady, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txBusy === 1'b0, "R9", txBusy, 0);
    check(rxEnable === 1'b1, "R9", rxEnable, 1);
    check(inReady === 1'b0, "R9", inReady, 0);
    check(lineRate === 1'b0, "R9", lineRate, 0);
    rstN = 1'b1;
    repeat (2 * STROBE_DIV) @(negedge clk);
    check(txBit === 1'b0, "R9", txBit, 0);

    payload[0] = 8'hA5; payload[1] = 8'h3C;
    runFrame(2, 2, 1'b1, 1'b1);                    // R1 R8 R7
    payload[0] = 8'hFF; payload[1] = 8'hFF; payload[2] = 8'h1F;
    runFrame(0, 3, 1'b1, 1'b0);                    // R2 floor, R3 across bytes
    payload[0] = 8'h7E;
    runFrame(5, 1, 1'b1, 1'b1);                    // R2 count, R3 flag-like data
    payload[0] = 8'h12; payload[1] = 8'hF8;
    runFrame(3, 2, 1'b0, 1'b0);                    // R5 underrun mid-payload
    runFrame(1, 0, 1'b0, 1'b1);                    // R5 no payload at all
    repeat (2 * STROBE_DIV) @(negedge clk);
    check(txBit === 1'b0, "R9", txBit, 0);
    summary();
    $finish;
  end
endmodule